// File: doc/BRIEF.md
# Cache Maintenance Command Queue Frontend

This block takes cache maintenance commands from several processors over one shared register bus. Every access on that bus carries the ID of the requester that made it. A single set of command registers holds the command being built: its mode word, start address, byte size, address mask and way selection. A requester claims these registers by writing the mode word. It keeps them while it fills in the other fields. It hands them back by reading its own registration status.

That read also commits the command. If the queue has room, the command is pushed into a small FIFO and the status reads zero. If the queue is full, the command is dropped and a full flag is returned instead. Any other requester that tries to claim the registers in the meantime fails. It learns of the failure through its own status.

A stub executor at the FIFO output runs one command at a time, in arrival order, for a fixed number of cycles. When a command finishes, the requester that issued it gets a completion flag, provided it asked for one. A sync primitive gives software a barrier: reading it back stalls the bus until every queued command has finished.

Top module: `cmq_frontend`

## Requirements
- R1: After reset no requester holds the command registers, the queue is empty, the executor is idle, and every requester reads 0 from both its registration status (0x25C) and its queue status (0x260).
- R2: The first requester to write the mode register (0x248) gains the right to the command registers. A mode write by any other requester while the right is held is refused. A refused requester's writes to address, size, mask or ways (0x24C, 0x250, 0x254, 0x258) leave the fields unchanged. Its next registration status read returns 1 (bit 0, lost arbitration) and clears that flag, so the read after it returns 0.
- R3: When the holder reads the registration status and the queue has room, the read returns 0, the command is pushed with the holder's ID, and the right is released so that another requester can win it.
- R4: When the holder reads the registration status while the queue already holds DEPTH commands, the read returns 2 (bit 1, queue full), nothing is pushed, and the right is still released.
- R5: The executor starts commands strictly in the order they were pushed. At each start pulse it presents the mode, address, size, mask, ways and requester ID that the command registers held when the command was pushed.
- R6: The executor runs one command at a time, and `exec_busy` stays high for exactly EXEC_LAT cycles per command.
- R7: Queue status bit 2 is the completion flag. It is set only for the issuing requester, and only when a finished command had mode bit 15 set. It stays set until that same requester writes the queue status with bit 2 at 1. A write with bit 2 at 0, or a write by another requester, leaves it unchanged.
- R8: Queue status bit 0 reads 1 while the requester has any command queued or executing. Bit 1 reads 1 while the executor runs one of that requester's commands.
- R9: Writing 8 (sync) or 9 (prefetch flush) to the primitive register (0x244) records the code, and other values are ignored. A read of 0x244 holds `bus_ready` low until the queue is empty and the executor is idle, then returns the recorded code.
- R10: A holder that writes the mode register again keeps the right, and the new mode word replaces the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rid | input | RID_W | Requester ID of the access |
| bus_ready | output | 1 | Access completes in a cycle with valid and ready both high |
| bus_rdata | output | 32 | Read data, valid while valid and ready are high |
| exec_start | output | 1 | One-cycle pulse when a command begins execution |
| exec_rid | output | RID_W | Requester of the running command |
| exec_mode | output | 32 | Mode word of the running command |
| exec_addr | output | 32 | Start address of the running command |
| exec_size | output | 32 | Byte size of the running command |
| exec_amask | output | 32 | Address mask of the running command |
| exec_ways | output | 32 | Way selection of the running command |
| exec_busy | output | 1 | Executor is running a command |

## Verification
The bench goes after the arbitration corners. A refused requester's field write must not leak into the holder's command; a design that let it through would execute the holder's command with a foreign address. A failed claim must be reported exactly once. The holder must lose its right even when the queue turns it away; a design that kept the right after a full-queue refusal would make the next requester read "lost arbitration" instead of "queue full". The completion flag is checked against writes with the wrong bit and writes from the wrong requester. The sync read-back is timed against a queue deliberately filled to capacity, so a barrier that let go early would return before the last start pulse had been seen.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

  localparam logic [11:0] OFF_PRIM  = 12'h244;
  localparam logic [11:0] OFF_MODE  = 12'h248;
  localparam logic [11:0] OFF_ADDR  = 12'h24C;
  localparam logic [11:0] OFF_SIZE  = 12'h250;
  localparam logic [11:0] OFF_AMASK = 12'h254;
  localparam logic [11:0] OFF_WAYS  = 12'h258;
  localparam logic [11:0] OFF_REGST = 12'h25C;
  localparam logic [11:0] OFF_QST   = 12'h260;

  localparam logic [31:0] PRIM_SYNC    = 32'h8;
  localparam logic [31:0] PRIM_PFFLUSH = 32'h9;
  localparam int          MODE_NOTIFY  = 15;
  localparam int          QST_DONE_BIT = 2;

  typedef struct packed {
    logic [31:0] mode;
    logic [31:0] addr;
    logic [31:0] size;
    logic [31:0] amask;
    logic [31:0] ways;
  } cmd_t;

  // registration status word: bit1 queue full, bit0 arbitration lost
  function automatic logic [31:0] pack_regst(input logic full_fail, input logic own_fail);
    pack_regst = {30'd0, full_fail, own_fail};
  endfunction

  // queue status word: bit2 done, bit1 running, bit0 outstanding
  function automatic logic [31:0] pack_qst(input logic done, input logic running, input logic pend);
    pack_qst = {29'd0, done, running, pend};
  endfunction

  function automatic logic is_prim_code(input logic [31:0] v);
    is_prim_code = (v == PRIM_SYNC) || (v == PRIM_PFFLUSH);
  endfunction

endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CMAX);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/cmq_lock.sv
module cmq_lock #(
  parameter int RID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [RID_W-1:0] take_id,
  input  logic             release_i,
  output logic             held,
  output logic [RID_W-1:0] holder
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      holder <= '0;
    end else if (take) begin
      held   <= 1'b1;
      holder <= take_id;
    end else if (release_i) begin
      held   <= 1'b0;
    end
  end

  p_keep_holder_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !release_i) |=> (held && holder == $past(holder)));
  p_release_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !take) |=> !held);

endmodule

// File: rtl/cmq_exec.sv
module cmq_exec #(
  parameter int LAT = 8,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         q_empty,
  input  logic [W-1:0] q_data,
  output logic         q_pop,
  output logic         busy,
  output logic         start,
  output logic         done,
  output logic [W-1:0] cur
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

  logic [CW-1:0] cnt;

  assign q_pop = !busy && !q_empty;
  assign done  = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      start <= 1'b0;
      cnt   <= '0;
      cur   <= '0;
    end else begin
      start <= q_pop;
      if (q_pop) begin
        busy <= 1'b1;
        cnt  <= LOAD;
        cur  <= q_data;
      end else if (done) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);
  p_done_idles_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/cmq_frontend.sv
module cmq_frontend
  import cmq_pkg::*;
#(
  parameter int RID_W    = 2,
  parameter int DEPTH    = 4,
  parameter int EXEC_LAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic [RID_W-1:0] bus_rid,
  output logic             bus_ready,
  output logic [31:0]      bus_rdata,
  output logic             exec_start,
  output logic [RID_W-1:0] exec_rid,
  output logic [31:0]      exec_mode,
  output logic [31:0]      exec_addr,
  output logic [31:0]      exec_size,
  output logic [31:0]      exec_amask,
  output logic [31:0]      exec_ways,
  output logic             exec_busy
);
  localparam int NREQ = 1 << RID_W;
  localparam int PW   = $bits(cmd_t) + RID_W;
  localparam int OCW  = $clog2(DEPTH + 2);

  // named internal events
  logic acc_wr, acc_rd, is_holder;
  logic mode_take, mode_lose, regst_rd, commit, do_push, q_pop;
  logic q_empty, q_full, ex_done, held;
  logic [RID_W-1:0] holder;
  logic [PW-1:0]    q_dout, ex_cur;
  cmd_t cmd_q, ex_cmd;
  logic [31:0] prim_q;
  logic [NREQ-1:0] lose_f, done_f, pend_f;

  assign bus_ready = !(bus_valid && !bus_write && bus_addr == OFF_PRIM &&
                       !(q_empty && !exec_busy));
  assign acc_wr    = bus_valid && bus_ready && bus_write;
  assign acc_rd    = bus_valid && bus_ready && !bus_write;
  assign is_holder = held && (holder == bus_rid);
  assign mode_take = acc_wr && bus_addr == OFF_MODE && (!held || is_holder);
  assign mode_lose = acc_wr && bus_addr == OFF_MODE && held && !is_holder;
  assign regst_rd  = acc_rd && bus_addr == OFF_REGST;
  assign commit    = regst_rd && is_holder;
  assign do_push   = commit && !q_full;

  cmq_lock #(.RID_W(RID_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .take(mode_take), .take_id(bus_rid),
    .release_i(commit), .held(held), .holder(holder)
  );

  cmq_fifo #(.DEPTH(DEPTH), .W(PW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(do_push), .din({bus_rid, cmd_q}),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  cmq_exec #(.LAT(EXEC_LAT), .W(PW)) u_exec (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_data(q_dout),
    .q_pop(q_pop), .busy(exec_busy), .start(exec_start), .done(ex_done),
    .cur(ex_cur)
  );

  assign exec_rid   = ex_cur[PW-1 -: RID_W];
  assign ex_cmd     = ex_cur[$bits(cmd_t)-1:0];
  assign exec_mode  = ex_cmd.mode;
  assign exec_addr  = ex_cmd.addr;
  assign exec_size  = ex_cmd.size;
  assign exec_amask = ex_cmd.amask;
  assign exec_ways  = ex_cmd.ways;

  // shared command registers, writable by the holder only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      prim_q <= '0;
    end else begin
      if (mode_take) cmd_q.mode <= bus_wdata;
      if (acc_wr && is_holder) begin
        case (bus_addr)
          OFF_ADDR:  cmd_q.addr  <= bus_wdata;
          OFF_SIZE:  cmd_q.size  <= bus_wdata;
          OFF_AMASK: cmd_q.amask <= bus_wdata;
          OFF_WAYS:  cmd_q.ways  <= bus_wdata;
          default: ;
        endcase
      end
      if (acc_wr && bus_addr == OFF_PRIM && is_prim_code(bus_wdata))
        prim_q <= bus_wdata;
    end
  end

  // per-requester banked status
  for (genvar r = 0; r < NREQ; r++) begin : g_req
    logic [OCW-1:0] outst;
    logic me, set_lose, clr_lose, set_done, clr_done, inc, dec;

    assign me       = (bus_rid == RID_W'(r));
    assign set_lose = mode_lose && me;
    assign clr_lose = regst_rd && me && !is_holder;
    assign set_done = ex_done && exec_rid == RID_W'(r) && exec_mode[MODE_NOTIFY];
    assign clr_done = acc_wr && me && bus_addr == OFF_QST && bus_wdata[QST_DONE_BIT];
    assign inc      = do_push && me;
    assign dec      = ex_done && exec_rid == RID_W'(r);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lose_f[r] <= 1'b0;
        done_f[r] <= 1'b0;
        outst     <= '0;
      end else begin
        if (set_lose)      lose_f[r] <= 1'b1;
        else if (clr_lose) lose_f[r] <= 1'b0;
        if (set_done)      done_f[r] <= 1'b1;
        else if (clr_done) done_f[r] <= 1'b0;
        if (inc && !dec)      outst <= outst + OCW'(1);
        else if (dec && !inc) outst <= outst - OCW'(1);
      end
    end
    assign pend_f[r] = (outst != '0);

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_f[r] && !clr_done) |=> done_f[r]);
    p_pend_covers_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_busy && exec_rid == RID_W'(r)) |-> pend_f[r]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        OFF_PRIM:  bus_rdata = prim_q;
        OFF_MODE:  bus_rdata = cmd_q.mode;
        OFF_ADDR:  bus_rdata = cmd_q.addr;
        OFF_SIZE:  bus_rdata = cmd_q.size;
        OFF_AMASK: bus_rdata = cmd_q.amask;
        OFF_WAYS:  bus_rdata = cmd_q.ways;
        OFF_REGST: bus_rdata = is_holder ? pack_regst(q_full, 1'b0)
                                         : pack_regst(1'b0, lose_f[bus_rid]);
        OFF_QST:   bus_rdata = pack_qst(done_f[bus_rid],
                                        exec_busy && exec_rid == bus_rid,
                                        pend_f[bus_rid]);
        default:   bus_rdata = '0;
      endcase
    end
  end

  p_prim_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == OFF_PRIM && (exec_busy || !q_empty))
      |-> !bus_ready);
  p_start_from_queue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> $past(!q_empty));

endmodule

// File: tb/cmq_frontend_test.sv
module cmq_frontend_test;
  localparam int RID_W = 2;
  localparam int DEPTH = 4;
  localparam int LAT   = 20;
  localparam int NV    = 23;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [RID_W-1:0] bus_rid = '0;
  logic bus_ready, exec_start, exec_busy;
  logic [31:0] bus_rdata, exec_mode, exec_addr, exec_size, exec_amask, exec_ways;
  logic [RID_W-1:0] exec_rid;

  always #2.5 clk = ~clk;

  cmq_frontend #(.RID_W(RID_W), .DEPTH(DEPTH), .EXEC_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rid(bus_rid),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .exec_start(exec_start),
    .exec_rid(exec_rid), .exec_mode(exec_mode), .exec_addr(exec_addr),
    .exec_size(exec_size), .exec_amask(exec_amask), .exec_ways(exec_ways),
    .exec_busy(exec_busy)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // execution log collected away from the clock edge
  logic [31:0] lg_mode [64], lg_addr [64], lg_size [64], lg_amask [64], lg_ways [64];
  logic [RID_W-1:0] lg_rid [64];
  int lg_len [64];
  int nstart = 0, nlen = 0, run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (exec_start && nstart < 64) begin
        lg_mode[nstart] = exec_mode;  lg_addr[nstart] = exec_addr;
        lg_size[nstart] = exec_size;  lg_amask[nstart] = exec_amask;
        lg_ways[nstart] = exec_ways;  lg_rid[nstart] = exec_rid;
        nstart++;
      end
      if (exec_busy) run++;
      else if (run != 0) begin
        if (nlen < 64) lg_len[nlen] = run;
        nlen++;
        run = 0;
      end
    end
  end

  task automatic op(input logic w, input logic [1:0] r, input logic [11:0] a,
                    input logic [31:0] d, output logic [31:0] rd, output int stall);
    stall = 0;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_rid = r; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin
      stall++;
      @(negedge clk);
      #1;
    end
    rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
  endtask

  // {write, rid, addr, wdata-or-expected, requirement number}
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 2'd0, 12'h248, 32'h0000_8002, 5'd2},
    {1'b1, 2'd1, 12'h248, 32'h0000_0001, 5'd2},
    {1'b1, 2'd1, 12'h24C, 32'h0000_DEAD, 5'd2},
    {1'b1, 2'd0, 12'h24C, 32'h0000_1000, 5'd5},
    {1'b1, 2'd0, 12'h250, 32'h0000_0080, 5'd5},
    {1'b1, 2'd0, 12'h254, 32'h0000_00FF, 5'd5},
    {1'b1, 2'd0, 12'h258, 32'h0000_0003, 5'd5},
    {1'b0, 2'd1, 12'h25C, 32'h0000_0001, 5'd2},
    {1'b0, 2'd1, 12'h25C, 32'h0000_0000, 5'd2},
    {1'b0, 2'd0, 12'h25C, 32'h0000_0000, 5'd3},
    {1'b1, 2'd1, 12'h248, 32'h0000_0001, 5'd3},
    {1'b0, 2'd1, 12'h25C, 32'h0000_0000, 5'd3},
    {1'b0, 2'd0, 12'h260, 32'h0000_0003, 5'd8},
    {1'b0, 2'd1, 12'h260, 32'h0000_0001, 5'd8},
    {1'b0, 2'd2, 12'h244, 32'h0000_0000, 5'd9},
    {1'b0, 2'd0, 12'h260, 32'h0000_0004, 5'd7},
    {1'b0, 2'd1, 12'h260, 32'h0000_0000, 5'd7},
    {1'b1, 2'd0, 12'h260, 32'h0000_0003, 5'd7},
    {1'b0, 2'd0, 12'h260, 32'h0000_0004, 5'd7},
    {1'b1, 2'd1, 12'h260, 32'h0000_0004, 5'd7},
    {1'b0, 2'd0, 12'h260, 32'h0000_0004, 5'd7},
    {1'b1, 2'd0, 12'h260, 32'h0000_0004, 5'd7},
    {1'b0, 2'd0, 12'h260, 32'h0000_0000, 5'd7}
  };

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int st, base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 busy", {31'd0, exec_busy}, 32'd0);
    chk("R1 start", {31'd0, exec_start}, 32'd0);
    op(1'b0, 2'd0, 12'h260, 0, rd, st); chk("R1 qst", rd, 32'd0);
    op(1'b0, 2'd2, 12'h25C, 0, rd, st); chk("R1 regst", rd, 32'd0);
    op(1'b0, 2'd3, 12'h244, 0, rd, st); chk("R1 prim no stall", st, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      v = VEC[i];
      op(v[51], v[50:49], v[48:37], v[36:5], rd, st);
      if (!v[51]) chk($sformatf("R%0d vec%0d", v[4:0], i), rd, v[36:5]);
    end
    chk("R5 two starts", nstart, 2);
    chk("R5 c0 mode", lg_mode[0], 32'h8002);
    chk("R5 c0 rid", lg_rid[0], 0);
    chk("R5 c0 addr", lg_addr[0], 32'h1000);
    chk("R5 c0 size", lg_size[0], 32'h80);
    chk("R5 c0 amask", lg_amask[0], 32'hFF);
    chk("R5 c0 ways", lg_ways[0], 32'h3);
    chk("R5 c1 rid", lg_rid[1], 1);
    chk("R5 c1 mode", lg_mode[1], 32'h1);
    chk("R2 foreign addr ignored", lg_addr[1], 32'h1000);

    // R4: fill the queue from requester 2
    base = nstart;
    for (int k = 1; k <= 6; k++) begin
      op(1'b1, 2'd2, 12'h248, k, rd, st);
      op(1'b0, 2'd2, 12'h25C, 0, rd, st);
      chk($sformatf("R4 regst k%0d", k), rd, (k <= 5) ? 32'd0 : 32'd2);
    end
    op(1'b0, 2'd2, 12'h260, 0, rd, st); chk("R8 running+pend", rd, 32'd3);
    op(1'b0, 2'd3, 12'h260, 0, rd, st); chk("R8 other idle", rd, 32'd0);
    op(1'b1, 2'd3, 12'h248, 32'h8004, rd, st);
    op(1'b0, 2'd3, 12'h25C, 0, rd, st); chk("R4 right released", rd, 32'd2);

    // R9: sync barrier
    op(1'b1, 2'd3, 12'h244, 32'h8, rd, st);
    op(1'b0, 2'd3, 12'h244, 0, rd, st);
    chk("R9 sync value", rd, 32'h8);
    chk("R9 stalled", {31'd0, st > 0}, 32'd1);
    chk("R9 drained", nstart - base, 5);
    for (int k = 0; k < 5; k++) begin
      chk($sformatf("R5 order %0d", k), lg_mode[base + k], k + 1);
      chk($sformatf("R5 rid %0d", k), lg_rid[base + k], 2);
    end
    for (int k = 0; k < nlen && k < 64; k++)
      chk($sformatf("R6 len %0d", k), lg_len[k], LAT);
    op(1'b0, 2'd2, 12'h260, 0, rd, st); chk("R7 no notify", rd, 32'd0);
    op(1'b1, 2'd3, 12'h244, 32'h5, rd, st);
    op(1'b0, 2'd3, 12'h244, 0, rd, st); chk("R9 bad code ignored", rd, 32'h8);
    op(1'b1, 2'd0, 12'h244, 32'h9, rd, st);
    op(1'b0, 2'd0, 12'h244, 0, rd, st); chk("R9 pf flush code", rd, 32'h9);

    // R10: holder rewrites mode
    base = nstart;
    op(1'b1, 2'd3, 12'h248, 32'h8003, rd, st);
    op(1'b1, 2'd0, 12'h248, 32'h0002, rd, st);
    op(1'b1, 2'd3, 12'h248, 32'h8007, rd, st);
    op(1'b0, 2'd0, 12'h25C, 0, rd, st); chk("R10 other lost", rd, 32'd1);
    op(1'b0, 2'd3, 12'h25C, 0, rd, st); chk("R10 holder kept", rd, 32'd0);
    op(1'b0, 2'd0, 12'h244, 0, rd, st);
    chk("R10 one start", nstart - base, 1);
    chk("R10 mode replaced", lg_mode[base], 32'h8007);
    chk("R10 rid", lg_rid[base], 3);
    op(1'b0, 2'd3, 12'h260, 0, rd, st); chk("R7 done r3", rd, 32'd4);
    op(1'b0, 2'd0, 12'h260, 0, rd, st); chk("R7 done not r0", rd, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule